// File: doc/BRIEF.md
# Ripple BCD Decade Counter

This block counts falling edges on a single count input and shows the result as one decimal digit, 0 through 9, on four binary-weighted outputs. It is a ripple design. Only the least significant flip-flop is clocked by the count input. Each higher flip-flop is clocked by the falling edge of a lower flip-flop's output, and one of these clocks is gated. The counter wraps from 9 to 0 because of how the flip-flop clocks are routed. No synchronous compare-and-clear is used.

The routing works as follows. Bit 0 toggles on every counted falling edge. Bit 1 toggles on a falling edge of bit 0, but only while bit 3 is low, so it stays at 0 on the step from 9 to 0. Bit 2 toggles on a falling edge of bit 1. Bit 3 is a data flip-flop clocked by the falling edge of bit 0. It loads the AND of bits 1 and 2, so it sets on the step from 7 to 8 and clears on the step from 9 to 0. It also receives clocks on the steps after 1, 3 and 5, and on those it reloads 0.

Reset is active low and clears all four flip-flops at once. Its release is synchronized to falling edges of the count input through a short chain of stages, and count edges that arrive during that chain are absorbed.

Top module: `bcd_ripple_decade`

## Requirements
- R1: While rst_n is low, the digit {bit3,bit2,bit1,bit0} reads 0 right away, without waiting for a count edge.
- R2: After rst_n rises, the first SYNC_STAGES falling edges of cnt_pulse (default 2) leave the digit at 0. The next falling edge makes it 1.
- R3: Once the counter is running, each falling edge of cnt_pulse raises the digit by one. Rising edges have no effect.
- R4: A falling edge of cnt_pulse with the digit at 9 returns it to 0.
- R5: After a reset, the digit never reads a value from 10 to 15.
- R6: While running, bit0 takes the opposite value after every falling edge of cnt_pulse.
- R7: Pulling rst_n low in the middle of a count sequence clears the digit. After release, counting starts again from 0, subject to R2.
- R8: Whenever bit3 is 1, bit1 and bit2 are both 0, so the only values with bit3 high are 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_pulse | input | 1 | Count input; every falling edge is one count |
| rst_n | input | 1 | Asynchronous reset, active low, with synchronized release |
| bit0 | output | 1 | Digit bit of weight 1 |
| bit1 | output | 1 | Digit bit of weight 2 |
| bit2 | output | 1 | Digit bit of weight 4 |
| bit3 | output | 1 | Digit bit of weight 8 |

## Verification
The assertions are sampled on falling edges of cnt_pulse. They assume the ripple from the previous edge has finished, which means each low and high phase of cnt_pulse must last longer than the worst chain of three flip-flop delays. They also assume rst_n changes only while cnt_pulse is low. The stimulus keeps to both conditions. It draws random phase widths that are never shorter than a few time units. It asserts and releases reset only during the low phase, and it samples the digit well after each falling edge.

// File: rtl/bcd_ripple_pkg.sv
package bcd_ripple_pkg;

  localparam int DIGIT_W   = 4;
  localparam int DIGIT_TOP = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Decimal successor, used by the checks in the top module.
  function automatic digit_t digit_succ(input digit_t cur);
    digit_t res;
    if (int'(cur) >= DIGIT_TOP) res = '0;
    else                        res = cur + digit_t'(1);
    return res;
  endfunction

endpackage

// File: rtl/bcd_ripple_rst_sync.sv
module bcd_ripple_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_fall,
  input  logic rst_n,
  output logic run_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(negedge clk_fall or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run_o = sync_q[STAGES-1];

endmodule

// File: rtl/bcd_ripple_stage.sv
module bcd_ripple_stage #(
  parameter bit SELF_TOGGLE = 1'b1
) (
  input  logic clk_fall,
  input  logic run,
  input  logic d_ext,
  output logic q_o
);

  logic q_reg;
  logic q_nxt;

  // Toggle variant feeds back its own inverse; data variant loads d_ext.
  always_comb q_nxt = SELF_TOGGLE ? ~q_reg : d_ext;

  always_ff @(negedge clk_fall or negedge run) begin
    if (!run) q_reg <= 1'b0;
    else      q_reg <= q_nxt;
  end

  assign q_o = q_reg;

endmodule

// File: rtl/bcd_ripple_decade.sv
module bcd_ripple_decade
  import bcd_ripple_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic cnt_pulse,
  input  logic rst_n,
  output logic bit0,
  output logic bit1,
  output logic bit2,
  output logic bit3
);

  localparam logic [DIGIT_W-1:0] TOGGLE_MASK = 4'b0111;

  logic                run;
  digit_t              q;
  logic [DIGIT_W-1:0]  stage_clk;
  logic [DIGIT_W-1:0]  stage_d;

  bcd_ripple_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_fall (cnt_pulse),
    .rst_n    (rst_n),
    .run_o    (run)
  );

  // Clock routing: all falling-edge active.
  always_comb begin
    stage_clk[0] = cnt_pulse;
    stage_clk[1] = q[0] & ~q[3];   // bit0 fall, blocked while bit3 set
    stage_clk[2] = q[1];
    stage_clk[3] = q[0];           // extra clocks at 1,3,5 reload 0
  end

  always_comb begin
    stage_d    = '0;
    stage_d[3] = q[1] & q[2];      // sets after 7, clears after 9
  end

  generate
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_stage
      bcd_ripple_stage #(
        .SELF_TOGGLE (TOGGLE_MASK[i])
      ) u_stage (
        .clk_fall (stage_clk[i]),
        .run      (run),
        .d_ext    (stage_d[i]),
        .q_o      (q[i])
      );
    end
  endgenerate

  assign bit0 = q[0];
  assign bit1 = q[1];
  assign bit2 = q[2];
  assign bit3 = q[3];

  // Sampled at count edges; ripple from the prior edge is settled by then.
  assert_in_range_R5 : assert property (@(negedge cnt_pulse) disable iff (!rst_n)
    int'(q) <= DIGIT_TOP);

  assert_step_R3 : assert property (@(negedge cnt_pulse) disable iff (!rst_n)
    (run && $past(run)) |-> (q == digit_succ($past(q))));

  assert_held_R2 : assert property (@(negedge cnt_pulse) disable iff (!rst_n)
    !run |-> (q == '0));

  assert_top_bit_R8 : assert property (@(negedge cnt_pulse) disable iff (!rst_n)
    q[3] |-> (!q[1] && !q[2]));

  assert_lsb_flip_R6 : assert property (@(negedge cnt_pulse) disable iff (!rst_n)
    (run && $past(run)) |-> (q[0] != $past(q[0])));

endmodule

// File: tb/bcd_ripple_decade_tb.sv
module bcd_ripple_decade_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic cnt_pulse;
  logic rst_n;
  logic bit0, bit1, bit2, bit3;

  int total = 0;
  int bad   = 0;
  int model = 0;
  int skip  = 0;
  bit done  = 0;

  bcd_ripple_decade #(.SYNC_STAGES(SYNC)) u_dut (
    .cnt_pulse (cnt_pulse),
    .rst_n     (rst_n),
    .bit0      (bit0),
    .bit1      (bit1),
    .bit2      (bit2),
    .bit3      (bit3)
  );

  function automatic int ref_next(input int v);
    return (v >= 9) ? 0 : v + 1;
  endfunction

  function automatic int digit();
    return {28'd0, bit3, bit2, bit1, bit0};
  endfunction

  task automatic check(input int exp, input string req);
    total++;
    if (digit() != exp) begin
      bad++;
      $display("FAIL %s: digit=%0d expected=%0d", req, digit(), exp);
    end
  endtask

  // One count pulse with given high/low widths, checked after ripple settles.
  task automatic pulse(input int hi, input int lo);
    int prev_b0;
    prev_b0 = bit0;
    cnt_pulse = 1'b1;
    #(hi);
    check(model, "R3 rising edge no effect");
    cnt_pulse = 1'b0;
    if (skip > 0) skip--;
    else          model = ref_next(model);
    #2;
    check(model, model == 0 ? "R4 wrap" : "R3 count");
    total++;
    if (digit() > 9) begin
      bad++;
      $display("FAIL R5: digit=%0d expected=<=9", digit());
    end
    total++;
    if (bit3 && (bit1 || bit2)) begin
      bad++;
      $display("FAIL R8: digit=%0d expected=8 or 9", digit());
    end
    if (skip == 0 && model != 0 || (skip == 0 && model == 0 && prev_b0 == 1)) begin
      total++;
      if (bit0 == prev_b0 && digit() == model && model != 0 && (model % 2) == prev_b0) begin
        bad++;
        $display("FAIL R6: bit0=%0d expected=%0d", bit0, !prev_b0);
      end
    end
    #(lo - 2);
  endtask

  task automatic do_reset(input string req);
    rst_n = 1'b0;
    #3;
    model = 0;
    check(0, req);
    #(CLK_PERIOD);
    rst_n = 1'b1;
    skip  = SYNC;
    #3;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
          bad++;
          total++;
          $display("FAIL watchdog: run did not end expected=finish");
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    cnt_pulse = 1'b0;
    rst_n     = 1'b0;
    #3;
    check(0, "R1 reset value");
    #(CLK_PERIOD);
    rst_n = 1'b1;
    skip  = SYNC;
    #3;

    // R2: absorbed edges after release
    pulse(CLK_PERIOD / 2, CLK_PERIOD / 2);
    check(0, "R2 first absorbed edge");
    pulse(CLK_PERIOD / 2, CLK_PERIOD / 2);
    check(0, "R2 second absorbed edge");
    pulse(CLK_PERIOD / 2, CLK_PERIOD / 2);
    check(1, "R2 first counted edge");

    // Directed: run through two full wraps
    for (int i = 0; i < 25; i++) pulse(CLK_PERIOD / 2, CLK_PERIOD / 2);
    check(6, "R4 after two wraps");

    // R7: reset mid-sequence
    do_reset("R7 mid-count clear");
    for (int i = 0; i < 4; i++) pulse(CLK_PERIOD / 2, CLK_PERIOD / 2);
    check(2, "R7 resumed count");

    // Reach 9, reset there, confirm clean restart
    for (int i = 0; i < 7; i++) pulse(CLK_PERIOD / 2, CLK_PERIOD / 2);
    check(9, "R3 reached nine");
    do_reset("R1 clear from nine");

    // Random widths with occasional resets
    for (int i = 0; i < 400; i++) begin
      int hi;
      int lo;
      hi = 3 + int'($urandom_range(0, 12));
      lo = 4 + int'($urandom_range(0, 12));
      if ($urandom_range(0, 39) == 0) do_reset("R7 random reset");
      pulse(hi, lo);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule